// File: doc/BRIEF.md
# Audio Frame Word-Select Generator

This block frames the serial output of an audio serializer. It counts bit positions inside a frame of programmable length, drives a word-select line that marks each frame, and shifts a left and a right sample onto one serial data line, most significant bit first, at programmable positions. It advances only on cycles where the bit-clock enable is high, so one system clock can serve any bit rate below it.

The word-select line is either a square wave with a duty cycle close to 50% or a one-bit-wide pulse. Either polarity can be chosen for the edge that marks a frame. A new configuration is checked against a minimum frame length that depends on the sample width and on mono or stereo operation. A configuration that is too short is refused and flagged. An accepted one is held and takes effect at the next frame boundary.

Samples arrive on a valid/ready stream. Ready is high for a single clock, on the bit step that starts a new frame. A transfer happens only when valid and ready are both high in that cycle. A source that is not valid at that moment does not stall the frame. The previous pair is sent again and the underrun output stays high for that frame. A source that holds valid high does not have to react to ready. Its pair is simply taken at the next frame start, and it must keep the pair stable until then.

Top module: `aud_frame_wsgen`

## Requirements
- R1: After reset the frame position is the last position of a 64-bit frame. The default configuration is 32-bit stereo, left at position 0, right at 32, 50% waveform, falling marking edge. So after reset ws is 0, and sd, frame_start, underrun, cfg_err and s_ready are all 0.
- R2: Each bit_en step moves the position by one, from 0 up to L-1, where L is the active frame length. frame_start is high for exactly one clock after the step that enters position 0, so consecutive frame_start pulses are L bit steps apart.
- R3: ws makes the frame-marking transition when the position enters L-1, one bit before bit 0. With cfg_rise=1 this transition is 0 to 1. With cfg_rise=0 it is 1 to 0.
- R4: In 50% mode (cfg_pulse=0) ws sits at its marking level at position L-1 and at positions 0 to A-2. A is floor(L/2) for a rising start and ceil(L/2) for a falling start. So the low phase takes the extra bit of an odd frame.
- R5: In pulse mode (cfg_pulse=1) ws is at its marking level only at position L-1.
- R6: Sample width is 16 bits (cfg_wide=0, using s_left/s_right bits 15:0) or 32 bits (cfg_wide=1). The left sample goes out MSB first at positions cfg_lpos onwards. Where the two windows overlap, left wins. Bits that would fall past L-1 are not sent.
- R7: In mono (cfg_stereo=0) the right window is ignored and those positions carry 0. In stereo (cfg_stereo=1) the right sample goes out MSB first from cfg_rpos.
- R8: Positions outside all active sample windows drive sd=0.
- R9: A write with cfg_len below the minimum is refused. The minimum is 36 for 32-bit stereo and 13 for every other mode. A refusal sets cfg_err and leaves both the active and the held configuration as they were. An accepted write clears cfg_err.
- R10: An accepted configuration takes effect from position 0 of the next frame. The frame in progress finishes with its old length and settings.
- R11: s_ready equals bit_en while the position is L-1, and is 0 otherwise. A pair taken then is sent for the whole following frame.
- R12: If s_valid is low when s_ready is high, the previous pair is sent again and underrun is 1 for that frame. The next accepted pair clears it.
- R13: While bit_en is low, position, ws, sd and the held samples do not change, and frame_start does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-clock enable, one serial bit per high cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len | input | 8 | Frame length in bits |
| cfg_rise | input | 1 | 1: rising edge marks a frame, 0: falling |
| cfg_pulse | input | 1 | 1: one-bit pulse, 0: near-50% square wave |
| cfg_wide | input | 1 | 1: 32-bit samples, 0: 16-bit samples |
| cfg_stereo | input | 1 | 1: stereo, 0: mono |
| cfg_lpos | input | 8 | First bit position of the left sample |
| cfg_rpos | input | 8 | First bit position of the right sample |
| cfg_err | output | 1 | Last write was refused for a short frame |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Pair accepted this cycle if valid |
| s_left | input | 32 | Left sample |
| s_right | input | 32 | Right sample |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| frame_start | output | 1 | One-clock strobe at bit 0 of each frame |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
On every cycle the assertions check the properties that do not depend on the waveform shape. They check that the position stays inside the active length and that the active length never drops below the minimum for its mode. They check that frame_start is a single clock wide and follows an accepted ready step. They also check that ready needs bit_en, that idle cycles freeze ws and sd, and that underrun and cfg_err rise only after a missed handshake or a write. The waveform itself is left to the directed scenarios: where the second ws edge falls for odd and even lengths of both polarities, pulse placement, MSB-first window placement with overlap and mono, and the deferral of new settings to the frame boundary.

// File: rtl/aud_ws_pkg.sv
package aud_ws_pkg;
  localparam int unsigned LEN_W           = 8;
  localparam int unsigned SAMP_W          = 32;
  localparam int unsigned NARROW_W        = 16;
  localparam int unsigned SEL_W           = $clog2(SAMP_W);
  localparam int unsigned MIN_LEN_STD     = 13;
  localparam int unsigned MIN_LEN_WIDE_ST = 36;
  localparam int unsigned NUM_CH          = 2;

  typedef logic [LEN_W-1:0]  pos_t;
  typedef logic [SAMP_W-1:0] samp_t;

  typedef struct packed {
    pos_t len;
    logic rise;
    logic pulse;
    logic wide;
    logic stereo;
    pos_t lpos;
    pos_t rpos;
  } frame_cfg_t;

  localparam frame_cfg_t DEF_CFG = '{
    len:    pos_t'(64),
    rise:   1'b0,
    pulse:  1'b0,
    wide:   1'b1,
    stereo: 1'b1,
    lpos:   pos_t'(0),
    rpos:   pos_t'(32)
  };

  // shortest legal frame for a sample width / channel count
  function automatic pos_t min_len(input logic wide, input logic stereo);
    return (wide && stereo) ? pos_t'(MIN_LEN_WIDE_ST) : pos_t'(MIN_LEN_STD);
  endfunction

  function automatic int width_of(input logic wide);
    return wide ? int'(SAMP_W) : int'(NARROW_W);
  endfunction

  // true when pos lies inside the sample window that starts at base
  function automatic logic in_window(input pos_t pos, input pos_t base, input logic wide);
    pos_t off;
    off = pos - base;
    return (pos >= base) && (int'(off) < width_of(wide));
  endfunction

  // bit of sample s shown at pos, MSB first from base
  function automatic logic window_bit(input samp_t s, input pos_t pos, input pos_t base,
                                      input logic wide);
    pos_t off;
    int   idx;
    off = pos - base;
    idx = width_of(wide) - 1 - int'(off);
    if (idx < 0 || idx >= int'(SAMP_W)) return 1'b0;
    return s[idx[SEL_W-1:0]];
  endfunction
endpackage

// File: rtl/aud_ws_cfg.sv
module aud_ws_cfg
  import aud_ws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  frame_cfg_t cfg_in,
  input  logic       wrap,
  output frame_cfg_t act,
  output logic       err
);
  frame_cfg_t act_q, pend_q;
  logic       pend_v_q, err_q;
  logic       too_short, accept;

  assign too_short = cfg_in.len < min_len(cfg_in.wide, cfg_in.stereo);
  assign accept    = wr && !too_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= DEF_CFG;
      pend_q   <= DEF_CFG;
      pend_v_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wrap && pend_v_q) act_q <= pend_q;
      if (accept) pend_q <= cfg_in;
      if (accept)    pend_v_q <= 1'b1;
      else if (wrap) pend_v_q <= 1'b0;
      if (wr) err_q <= too_short;
    end
  end

  assign act = act_q;
  assign err = err_q;
endmodule

// File: rtl/aud_ws_counter.sv
module aud_ws_counter
  import aud_ws_pkg::*;
#(
  parameter pos_t RST_POS = DEF_CFG.len - pos_t'(1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  pos_t len,
  output pos_t pos,
  output logic wrap,
  output logic fs
);
  pos_t pos_q;
  logic fs_q;
  pos_t last;

  assign last = len - pos_t'(1);
  assign wrap = bit_en && (pos_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= RST_POS;
      fs_q  <= 1'b0;
    end else begin
      fs_q <= wrap;
      if (bit_en) pos_q <= wrap ? '0 : pos_q + pos_t'(1);
    end
  end

  assign pos = pos_q;
  assign fs  = fs_q;
endmodule

// File: rtl/aud_ws_shaper.sv
module aud_ws_shaper
  import aud_ws_pkg::*;
(
  input  pos_t pos,
  input  pos_t len,
  input  logic rise,
  input  logic pulse,
  output logic ws
);
  logic [LEN_W:0] len_x, half, pos_x;
  logic           at_mark, in_first, marking;

  assign len_x = {1'b0, len};
  assign pos_x = {1'b0, pos};
  // the marking half gets the extra bit only when it is the low half
  assign half  = rise ? (len_x >> 1) : ((len_x + (LEN_W+1)'(1)) >> 1);

  assign at_mark  = (pos == len - pos_t'(1));
  assign in_first = !pulse && ((pos_x + (LEN_W+1)'(1)) < half);
  assign marking  = at_mark || in_first;
  assign ws       = rise ? marking : !marking;
endmodule

// File: rtl/aud_ws_data.sv
module aud_ws_data
  import aud_ws_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  s_valid,
  input  samp_t s_left,
  input  samp_t s_right,
  input  pos_t  pos,
  input  logic  wide,
  input  logic  stereo,
  input  pos_t  lpos,
  input  pos_t  rpos,
  output logic  sd,
  output logic  underrun
);
  samp_t smp_q [NUM_CH];
  logic  und_q;
  logic [NUM_CH-1:0] hit, bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q[0] <= '0;
      smp_q[1] <= '0;
      und_q    <= 1'b0;
    end else if (take) begin
      und_q <= !s_valid;
      if (s_valid) begin
        smp_q[0] <= s_left;
        smp_q[1] <= s_right;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pos_t base;
    logic ch_on;
    assign base     = (ch == 0) ? lpos : rpos;
    assign ch_on    = (ch == 0) ? 1'b1 : stereo;
    assign hit[ch]  = ch_on && in_window(pos, base, wide);
    assign bits[ch] = window_bit(smp_q[ch], pos, base, wide);
  end

  always_comb begin
    if (hit[0])      sd = bits[0];
    else if (hit[1]) sd = bits[1];
    else             sd = 1'b0;
  end

  assign underrun = und_q;
endmodule

// File: rtl/aud_frame_wsgen.sv
module aud_frame_wsgen
  import aud_ws_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_len,
  input  logic        cfg_rise,
  input  logic        cfg_pulse,
  input  logic        cfg_wide,
  input  logic        cfg_stereo,
  input  logic [7:0]  cfg_lpos,
  input  logic [7:0]  cfg_rpos,
  output logic        cfg_err,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_left,
  input  logic [31:0] s_right,
  output logic        ws,
  output logic        sd,
  output logic        frame_start,
  output logic        underrun
);
  frame_cfg_t cfg_in, act;
  pos_t       pos_q;
  logic       wrap;

  assign cfg_in = '{len: cfg_len, rise: cfg_rise, pulse: cfg_pulse, wide: cfg_wide,
                    stereo: cfg_stereo, lpos: cfg_lpos, rpos: cfg_rpos};

  aud_ws_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .cfg_in (cfg_in),
    .wrap   (wrap),
    .act    (act),
    .err    (cfg_err)
  );

  aud_ws_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .len    (act.len),
    .pos    (pos_q),
    .wrap   (wrap),
    .fs     (frame_start)
  );

  aud_ws_shaper u_shape (
    .pos   (pos_q),
    .len   (act.len),
    .rise  (act.rise),
    .pulse (act.pulse),
    .ws    (ws)
  );

  aud_ws_data u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (wrap),
    .s_valid  (s_valid),
    .s_left   (s_left),
    .s_right  (s_right),
    .pos      (pos_q),
    .wide     (act.wide),
    .stereo   (act.stereo),
    .lpos     (act.lpos),
    .rpos     (act.rpos),
    .sd       (sd),
    .underrun (underrun)
  );

  assign s_ready = wrap;
endmodule

// File: rtl/aud_frame_wsgen_chk.sv
module aud_frame_wsgen_chk
  import aud_ws_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic cfg_wr,
  input logic cfg_err,
  input logic s_valid,
  input logic s_ready,
  input logic ws,
  input logic sd,
  input logic frame_start,
  input logic underrun,
  input pos_t pos,
  input pos_t len,
  input logic wide,
  input logic stereo
);
  assert_pos_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos < len);

  assert_fs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_fs_after_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> frame_start);

  assert_ready_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_en);

  assert_len_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len >= min_len(wide, stereo));

  assert_err_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_wr));

  assert_underrun_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(s_ready && !s_valid));

  assert_underrun_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> !underrun);

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(ws) && $stable(sd) && !frame_start));
endmodule

bind aud_frame_wsgen aud_frame_wsgen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .cfg_wr      (cfg_wr),
  .cfg_err     (cfg_err),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .ws          (ws),
  .sd          (sd),
  .frame_start (frame_start),
  .underrun    (underrun),
  .pos         (pos_q),
  .len         (act.len),
  .wide        (act.wide),
  .stereo      (act.stereo)
);

// File: tb/aud_frame_wsgen_test.sv
module aud_frame_wsgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_len = '0;
  logic        cfg_rise = 1'b0, cfg_pulse = 1'b0, cfg_wide = 1'b0, cfg_stereo = 1'b0;
  logic [7:0]  cfg_lpos = '0, cfg_rpos = '0;
  logic        cfg_err;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_left = '0, s_right = '0;
  logic        ws, sd, frame_start, underrun;

  int checks = 0;
  int errors = 0;

  // bench-side expectation of the configuration and frame state
  int m_len = 64, m_pos = 63, m_lpos = 0, m_rpos = 32;
  bit m_rise = 0, m_pulse = 0, m_wide = 1, m_stereo = 1;
  int p_len, p_lpos, p_rpos;
  bit p_rise, p_pulse, p_wide, p_stereo, p_v = 0;
  logic [31:0] m_left = '0, m_right = '0, nxt_l = 32'hA5C3_0F81, nxt_r = 32'h3C96_E1D2;
  bit m_und = 0, m_fs = 0, m_err = 0, drv_valid = 1;

  always #10 clk = ~clk;

  aud_frame_wsgen uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
    .cfg_rise(cfg_rise), .cfg_pulse(cfg_pulse), .cfg_wide(cfg_wide),
    .cfg_stereo(cfg_stereo), .cfg_lpos(cfg_lpos), .cfg_rpos(cfg_rpos),
    .cfg_err(cfg_err), .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
    .s_right(s_right), .ws(ws), .sd(sd), .frame_start(frame_start), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_ws(input int p);
    int  a;
    bit  mk;
    a  = m_rise ? m_len / 2 : (m_len + 1) / 2;
    mk = (p == m_len - 1) || (!m_pulse && p < a - 1);
    return m_rise ? mk : !mk;
  endfunction

  function automatic bit e_sd(input int p);
    int w;
    w = m_wide ? 32 : 16;
    if (p >= m_lpos && p - m_lpos < w) return m_left[w - 1 - (p - m_lpos)];
    if (m_stereo && p >= m_rpos && p - m_rpos < w) return m_right[w - 1 - (p - m_rpos)];
    return 1'b0;
  endfunction

  task automatic check_outputs();
    chk(ws == e_ws(m_pos), "R3/R4/R5 ws", 32'(ws), 32'(e_ws(m_pos)));
    chk(sd == e_sd(m_pos), "R6/R7/R8 sd", 32'(sd), 32'(e_sd(m_pos)));
    chk(frame_start == m_fs, "R2 frame_start", 32'(frame_start), 32'(m_fs));
    chk(underrun == m_und, "R12 underrun", 32'(underrun), 32'(m_und));
  endtask

  // one system clock; starts and ends just after a falling edge
  task automatic tick(input bit en);
    bit wrap;
    bit_en  = en;
    s_valid = drv_valid;
    s_left  = nxt_l;
    s_right = nxt_r;
    #1;
    wrap = en && (m_pos == m_len - 1);
    chk(s_ready == wrap, "R11 s_ready", 32'(s_ready), 32'(wrap));
    @(posedge clk);
    @(negedge clk);
    m_fs = wrap;
    if (en) begin
      if (wrap) begin
        m_pos = 0;
        if (p_v) begin
          m_len = p_len; m_rise = p_rise; m_pulse = p_pulse; m_wide = p_wide;
          m_stereo = p_stereo; m_lpos = p_lpos; m_rpos = p_rpos; p_v = 0;
        end
        if (drv_valid) begin
          m_left = nxt_l; m_right = nxt_r; m_und = 0;
          nxt_l = nxt_l * 32'h0100_0193 + 32'h1357;
          nxt_r = nxt_r * 32'h0019_660D + 32'h2468;
        end else m_und = 1;
      end else m_pos++;
    end
    check_outputs();
  endtask

  task automatic write_cfg(input int len, input bit rise, input bit pulse, input bit wide,
                           input bit stereo, input int lpos, input int rpos);
    bit bad;
    bit_en = 1'b0;
    cfg_wr = 1'b1; cfg_len = 8'(len); cfg_rise = rise; cfg_pulse = pulse;
    cfg_wide = wide; cfg_stereo = stereo; cfg_lpos = 8'(lpos); cfg_rpos = 8'(rpos);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    bad = len < ((wide && stereo) ? 36 : 13);
    m_err = bad;
    if (!bad) begin
      p_len = len; p_rise = rise; p_pulse = pulse; p_wide = wide;
      p_stereo = stereo; p_lpos = lpos; p_rpos = rpos; p_v = 1;
    end
    chk(cfg_err == m_err, "R9 cfg_err", 32'(cfg_err), 32'(m_err));
  endtask

  // finish the current frame, then run k whole frames
  task automatic next_frames(input int k);
    while (m_pos != m_len - 1) tick(1);
    tick(1);
    repeat (k * m_len - 1) tick(1);
  endtask

  task automatic t_reset();
    chk(ws == 1'b0, "R1 ws", 32'(ws), 0);
    chk(sd == 1'b0, "R1 sd", 32'(sd), 0);
    chk(frame_start == 1'b0, "R1 frame_start", 32'(frame_start), 0);
    chk(underrun == 1'b0, "R1 underrun", 32'(underrun), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", 32'(cfg_err), 0);
    chk(s_ready == 1'b0, "R1 s_ready", 32'(s_ready), 0);
  endtask

  task automatic t_default();
    next_frames(2);
  endtask

  task automatic t_mono16_odd_rise();
    write_cfg(21, 1, 0, 0, 0, 2, 5);   // R7: right window must stay silent
    next_frames(3);
  endtask

  task automatic t_stereo16_odd_fall();
    write_cfg(37, 0, 0, 0, 1, 1, 19);
    next_frames(2);
  endtask

  task automatic t_pulse();
    write_cfg(40, 1, 1, 0, 1, 0, 20);
    next_frames(2);
  endtask

  // R10: frame in progress keeps old length, next frame uses new one
  task automatic t_boundary();
    int n;
    while (!(m_pos == 0 && m_fs)) tick(1);
    repeat (5) tick(1);
    write_cfg(24, 0, 1, 0, 1, 3, 12);
    n = 0;
    do begin tick(1); n++; end while (!frame_start && n < 300);
    chk(n == 35, "R10 old frame length", 32'(n), 35);
    n = 0;
    do begin tick(1); n++; end while (!frame_start && n < 300);
    chk(n == 24, "R10 new frame length", 32'(n), 24);
  endtask

  task automatic t_overlap();
    write_cfg(30, 1, 0, 0, 1, 4, 4);   // R6: left wins where windows overlap
    next_frames(2);
  endtask

  task automatic t_reject();
    write_cfg(36, 0, 0, 1, 1, 0, 18);
    next_frames(1);
    write_cfg(35, 1, 1, 1, 1, 0, 0);   // R9: too short for 32-bit stereo
    next_frames(1);
    chk(frame_start == 1'b0 && m_len == 36, "R9 kept length", 32'(m_len), 36);
    write_cfg(12, 0, 0, 0, 0, 0, 0);   // R9: too short for 16-bit mono
    write_cfg(13, 0, 0, 0, 0, 0, 0);
    chk(cfg_err == 1'b0, "R9 accepted clears", 32'(cfg_err), 0);
    next_frames(2);
  endtask

  task automatic t_underrun();
    drv_valid = 0;
    next_frames(1);
    chk(underrun == 1'b1, "R12 underrun set", 32'(underrun), 1);
    drv_valid = 1;
    next_frames(1);
    chk(underrun == 1'b0, "R12 underrun cleared", 32'(underrun), 0);
  endtask

  task automatic t_gaps();
    logic w0, s0;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      w0 = ws; s0 = sd;
      tick(0);
      tick(0);
      chk(ws == w0 && sd == s0, "R13 hold", {30'd0, ws, sd}, {30'd0, w0, s0});
      chk(frame_start == 1'b0, "R13 no strobe", 32'(frame_start), 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_default();
    t_mono16_odd_rise();
    t_stereo16_odd_fall();
    t_pulse();
    t_boundary();
    t_overlap();
    t_reject();
    t_underrun();
    t_gaps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule